// File: doc/BRIEF.md
# Remappable Memory Address Decoder

This block sits between a processor's address bus and the on-chip targets. Each cycle it may receive a 32-bit byte address with a valid strobe. It registers that access and, from the registered copy, raises exactly one region select: SRAM, flash or the peripheral register space. It also reports the byte offset inside the selected region. An address that falls in no region raises an error flag instead of a select.

The lowest 64 KB of the address space is a mirror window. It shows flash after reset. A single control bit, written through a dedicated strobe, retargets the window to SRAM. The 8 KB SRAM then repeats every 8 KB across the window. The memories, their wait states and the peripheral register contents belong to other blocks.

Top module: `mem_addr_decode`

## Requirements
- R1: After reset the control bit is 1, so an access to address 0x00000000 selects flash with offset 0.
- R2: An access in 0x00010000..0x00011FFF selects SRAM (region_sel = 3'b001) with offset equal to the address minus 0x00010000.
- R3: An access in 0x00080000..0x0008FFFF selects flash (region_sel = 3'b010) with offset equal to the address minus 0x00080000.
- R4: An access in 0xFFFF0000..0xFFFFFFFF selects the peripheral region (region_sel = 3'b100) with offset equal to the address minus 0xFFFF0000.
- R5: While the control bit is 1, an access in 0x00000000..0x0000FFFF selects flash with offset equal to the address.
- R6: While the control bit is 0, an access in 0x00000000..0x0000FFFF selects SRAM with offset equal to the address modulo 0x2000.
- R7: A cycle with remap_wr high loads remap_wdata into the control bit at that clock edge. Every access sampled at a later edge decodes with the new value.
- R8: While remap_wr is low, remap_wdata has no effect on the control bit or on any decode.
- R9: A valid access outside all regions drives decode_err high for one cycle, with region_sel = 0 and region_ofs = 0.
- R10: In a cycle after an edge that sampled bus_valid low, region_sel, region_ofs and decode_err are all 0. This also holds in the cycle right after reset.
- R11: Outputs describe the access sampled at the most recent clock edge (one cycle of latency), and region_sel never has more than one bit set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, deasserted synchronously to clk |
| bus_valid | input | 1 | Access present on bus_addr this cycle |
| bus_addr | input | 32 | Byte address of the access |
| remap_wr | input | 1 | Write strobe for the remap control bit |
| remap_wdata | input | 1 | New control bit value: 1 = flash in low window, 0 = SRAM |
| region_sel | output | 3 | One-hot select: bit 0 SRAM, bit 1 flash, bit 2 peripheral |
| region_ofs | output | 16 | Byte offset inside the selected region |
| decode_err | output | 1 | Valid access to an unmapped address |

## Verification
Several rules are checked by assertions on every cycle. These are the at-most-one-hot select and the quiet outputs after an idle edge. Also covered are the rule that an error carries no select and no offset, and the hold and load behaviour of the control bit. The bench has to show the address map itself. It sweeps every region boundary and strides through each region with both control-bit values. This shows the correct offsets, the 8 KB wrap of SRAM in the low window and the latency of a remap write. Throughout, the bench drives the opposite value on remap_wdata while the strobe is low.

// File: rtl/memdec_pkg.sv
package memdec_pkg;

  // select bit positions, decoded by the memory ports downstream
  localparam int SEL_SRAM   = 0;
  localparam int SEL_FLASH  = 1;
  localparam int SEL_PERIPH = 2;
  localparam int SEL_W      = 3;

  // window indices inside the decoder
  typedef enum int {
    WIN_SRAM   = 0,
    WIN_FLASH  = 1,
    WIN_PERIPH = 2,
    WIN_LOW    = 3
  } win_e;
  localparam int NWIN = 4;

  function automatic logic [31:0] size_mask(input int lg);
    if (lg >= 32) return '1;
    return (32'h1 << lg) - 32'h1;
  endfunction

endpackage

// File: rtl/memdec_remap_reg.sv
module memdec_remap_reg #(
  parameter logic RST_VAL = 1'b1
) (
  input  logic clk,
  input  logic rst_n,
  input  logic wr_en,
  input  logic wr_bit,
  output logic map_flash
);

  logic map_q;
  logic map_d;

  always_comb begin
    map_d = map_q;
    if (wr_en) map_d = wr_bit;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) map_q <= RST_VAL;
    else        map_q <= map_d;
  end

  assign map_flash = map_q;

  AST_REMAP_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_en |=> $stable(map_flash)); // R8
  AST_REMAP_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |=> (map_flash == $past(wr_bit))); // R7

endmodule

// File: rtl/memdec_window.sv
module memdec_window #(
  parameter logic [31:0] BASE  = 32'h0,
  parameter int          LG    = 16,
  parameter int          OFS_W = 16
) (
  input  logic [31:0]      addr,
  output logic             hit,
  output logic [OFS_W-1:0] ofs
);

  localparam logic [31:0] MASK = memdec_pkg::size_mask(LG);

  // window is size-aligned: compare only the bits above the size
  assign hit = (((addr ^ BASE) & ~MASK) == 32'h0);
  assign ofs = addr[OFS_W-1:0] & MASK[OFS_W-1:0];

endmodule

// File: rtl/memdec_route.sv
module memdec_route #(
  parameter int OFS_W    = 16,
  parameter int SRAM_LG  = 13,
  parameter int FLASH_LG = 16
) (
  input  logic                         vld,
  input  logic                         map_flash,
  input  logic [memdec_pkg::NWIN-1:0]  hit,
  input  logic [OFS_W-1:0]             win_ofs [memdec_pkg::NWIN],
  output logic [memdec_pkg::SEL_W-1:0] sel,
  output logic [OFS_W-1:0]             ofs,
  output logic                         err
);
  import memdec_pkg::*;

  localparam logic [31:0] SRAM_M  = size_mask(SRAM_LG);
  localparam logic [31:0] FLASH_M = size_mask(FLASH_LG);

  always_comb begin
    sel = '0;
    ofs = '0;
    err = 1'b0;
    if (vld) begin
      if (hit[WIN_SRAM]) begin
        sel[SEL_SRAM] = 1'b1;
        ofs           = win_ofs[WIN_SRAM];
      end else if (hit[WIN_FLASH]) begin
        sel[SEL_FLASH] = 1'b1;
        ofs            = win_ofs[WIN_FLASH];
      end else if (hit[WIN_PERIPH]) begin
        sel[SEL_PERIPH] = 1'b1;
        ofs             = win_ofs[WIN_PERIPH];
      end else if (hit[WIN_LOW]) begin
        if (map_flash) begin
          sel[SEL_FLASH] = 1'b1;
          ofs            = win_ofs[WIN_LOW] & FLASH_M[OFS_W-1:0];
        end else begin
          sel[SEL_SRAM] = 1'b1;
          ofs           = win_ofs[WIN_LOW] & SRAM_M[OFS_W-1:0];
        end
      end else begin
        err = 1'b1;
      end
    end
  end

endmodule

// File: rtl/mem_addr_decode.sv
module mem_addr_decode #(
  parameter logic [31:0] SRAM_BASE    = 32'h0001_0000,
  parameter int          SRAM_BYTES   = 8192,
  parameter logic [31:0] FLASH_BASE   = 32'h0008_0000,
  parameter int          FLASH_BYTES  = 65536,
  parameter logic [31:0] PERIPH_BASE  = 32'hFFFF_0000,
  parameter int          PERIPH_BYTES = 65536,
  parameter int          LOW_BYTES    = 65536,
  parameter int          OFS_W        = 16,
  parameter logic        REMAP_RST    = 1'b1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_valid,
  input  logic [31:0]       bus_addr,
  input  logic              remap_wr,
  input  logic              remap_wdata,
  output logic [2:0]        region_sel,
  output logic [OFS_W-1:0]  region_ofs,
  output logic              decode_err
);
  import memdec_pkg::*;

  localparam int SRAM_LG   = $clog2(SRAM_BYTES);
  localparam int FLASH_LG  = $clog2(FLASH_BYTES);
  localparam int PERIPH_LG = $clog2(PERIPH_BYTES);
  localparam int LOW_LG    = $clog2(LOW_BYTES);

  localparam logic [31:0] WIN_BASE [NWIN] = '{SRAM_BASE, FLASH_BASE, PERIPH_BASE, 32'h0};
  localparam int          WIN_LG   [NWIN] = '{SRAM_LG, FLASH_LG, PERIPH_LG, LOW_LG};

  // ---- access register ----
  logic        vld_q, vld_d;
  logic [31:0] addr_q, addr_d;

  always_comb begin
    vld_d  = bus_valid;
    addr_d = addr_q;
    if (bus_valid) addr_d = bus_addr;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      vld_q  <= 1'b0;
      addr_q <= '0;
    end else begin
      vld_q  <= vld_d;
      addr_q <= addr_d;
    end
  end

  // ---- remap control bit ----
  logic map_flash;

  memdec_remap_reg #(.RST_VAL(REMAP_RST)) u_remap (
    .clk       (clk),
    .rst_n     (rst_n),
    .wr_en     (remap_wr),
    .wr_bit    (remap_wdata),
    .map_flash (map_flash)
  );

  // ---- window comparators ----
  logic [NWIN-1:0] win_hit;
  logic [OFS_W-1:0] win_ofs [NWIN];

  for (genvar gi = 0; gi < NWIN; gi++) begin : g_win
    memdec_window #(
      .BASE  (WIN_BASE[gi]),
      .LG    (WIN_LG[gi]),
      .OFS_W (OFS_W)
    ) u_win (
      .addr (addr_q),
      .hit  (win_hit[gi]),
      .ofs  (win_ofs[gi])
    );
  end

  // ---- priority route to one-hot select ----
  memdec_route #(
    .OFS_W    (OFS_W),
    .SRAM_LG  (SRAM_LG),
    .FLASH_LG (FLASH_LG)
  ) u_route (
    .vld       (vld_q),
    .map_flash (map_flash),
    .hit       (win_hit),
    .win_ofs   (win_ofs),
    .sel       (region_sel),
    .ofs       (region_ofs),
    .err       (decode_err)
  );

  AST_SEL_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(region_sel)); // R11
  AST_ERR_NO_SEL: assert property (@(posedge clk) disable iff (!rst_n)
    decode_err |-> (region_sel == '0 && region_ofs == '0)); // R9
  AST_ERR_FROM_ACCESS: assert property (@(posedge clk) disable iff (!rst_n)
    decode_err |-> $past(bus_valid)); // R9
  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(bus_valid) |-> (region_sel == '0 && !decode_err && region_ofs == '0)); // R10

endmodule

// File: tb/sim_mem_addr_decode.sv
module sim_mem_addr_decode;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        bus_valid;
  logic [31:0] bus_addr;
  logic        remap_wr;
  logic        remap_wdata;
  logic [2:0]  region_sel;
  logic [15:0] region_ofs;
  logic        decode_err;

  int  vectors = 0;
  int  miscompares = 0;
  bit  done = 1'b0;
  logic map_m = 1'b1;   // bench's own view of the control bit
  logic [31:0] last_addr = '0;

  always #5 clk = ~clk;

  mem_addr_decode u0 (
    .clk         (clk),
    .rst_n       (rst_n),
    .bus_valid   (bus_valid),
    .bus_addr    (bus_addr),
    .remap_wr    (remap_wr),
    .remap_wdata (remap_wdata),
    .region_sel  (region_sel),
    .region_ofs  (region_ofs),
    .decode_err  (decode_err)
  );

  task automatic check(input string req, input logic [2:0] es,
                       input logic [15:0] eo, input logic ee);
    vectors++;
    if (region_sel !== es || region_ofs !== eo || decode_err !== ee) begin
      miscompares++;
      $display("FAIL %s addr=%h got sel=%b ofs=%h err=%b expected sel=%b ofs=%h err=%b",
               req, last_addr, region_sel, region_ofs, decode_err, es, eo, ee);
    end
  endtask

  // arithmetic model of the address map
  task automatic expect_for(input logic [31:0] a, input logic m, output string req,
                            output logic [2:0] es, output logic [15:0] eo, output logic ee);
    es = 3'b000; eo = 16'h0; ee = 1'b0;
    if (a >= 32'h0001_0000 && a <= 32'h0001_1FFF) begin
      req = "R2"; es = 3'b001; eo = 16'(a - 32'h0001_0000);
    end else if (a >= 32'h0008_0000 && a <= 32'h0008_FFFF) begin
      req = "R3"; es = 3'b010; eo = 16'(a - 32'h0008_0000);
    end else if (a >= 32'hFFFF_0000) begin
      req = "R4"; es = 3'b100; eo = 16'(a - 32'hFFFF_0000);
    end else if (a <= 32'h0000_FFFF) begin
      if (m) begin req = "R5"; es = 3'b010; eo = 16'(a); end
      else   begin req = "R6"; es = 3'b001; eo = 16'(a % 32'h2000); end
    end else begin
      req = "R9"; ee = 1'b1;
    end
  endtask

  // drive at a falling edge, check at the next falling edge (R11 latency)
  task automatic apply(input logic [31:0] a);
    string r; logic [2:0] es; logic [15:0] eo; logic ee;
    bus_valid   = 1'b1;
    bus_addr    = a;
    remap_wr    = 1'b0;
    remap_wdata = ~map_m;   // R8: opposite value with strobe low
    last_addr   = a;
    @(negedge clk);
    expect_for(a, map_m, r, es, eo, ee);
    check(r, es, eo, ee);
  endtask

  task automatic idle_check();
    bus_valid   = 1'b0;
    bus_addr    = 32'h0008_0010;
    remap_wr    = 1'b0;
    remap_wdata = ~map_m;
    @(negedge clk);
    check("R10", 3'b000, 16'h0, 1'b0);
  endtask

  task automatic write_map(input logic v);
    bus_valid   = 1'b0;
    remap_wr    = 1'b1;
    remap_wdata = v;
    @(negedge clk);
    map_m = v;
    check("R10", 3'b000, 16'h0, 1'b0);
    remap_wr = 1'b0;
  endtask

  task automatic sweep_region(input logic [31:0] base, input int size);
    for (int i = -600; i < size + 600; i += 'h1F7) apply(base + 32'(i));
    apply(base - 32'h1);
    apply(base);
    apply(base + 32'(size) - 32'h1);
    apply(base + 32'(size));
  endtask

  task automatic full_sweep();
    sweep_region(32'h0000_0000, 'h10000);
    sweep_region(32'h0001_0000, 'h2000);
    sweep_region(32'h0008_0000, 'h10000);
    sweep_region(32'hFFFF_0000, 'h10000);
    for (int k = 0; k < 512; k++) apply(32'(k) * 32'h0080_1403);
    idle_check();
  endtask

  initial begin
    rst_n       = 1'b0;
    bus_valid   = 1'b0;
    bus_addr    = '0;
    remap_wr    = 1'b0;
    remap_wdata = 1'b0;
    repeat (3) @(negedge clk);
    check("R10", 3'b000, 16'h0, 1'b0);          // reset state
    rst_n = 1'b1;
    @(negedge clk);
    check("R10", 3'b000, 16'h0, 1'b0);

    // R1: flash mirrored at zero after reset
    bus_valid = 1'b1; bus_addr = 32'h0; remap_wdata = 1'b0; last_addr = 32'h0;
    @(negedge clk);
    check("R1", 3'b010, 16'h0, 1'b0);
    idle_check();

    // R9: one-cycle error then quiet
    apply(32'h0002_0000);
    idle_check();

    full_sweep();                                  // control bit = 1

    // R7: SRAM takes over the low window on the next access
    write_map(1'b0);
    bus_valid = 1'b1; bus_addr = 32'h0000_2345; last_addr = bus_addr;
    remap_wr = 1'b0; remap_wdata = 1'b1;
    @(negedge clk);
    check("R7", 3'b001, 16'h0345, 1'b0);

    full_sweep();                                  // control bit = 0

    // R6: wrap at the top of the low window
    apply(32'h0000_FFFF);
    apply(32'h0000_E000);

    // R7: back to flash
    write_map(1'b1);
    bus_valid = 1'b1; bus_addr = 32'h0000_2345; last_addr = bus_addr;
    remap_wr = 1'b0; remap_wdata = 1'b0;
    @(negedge clk);
    check("R7", 3'b010, 16'h2345, 1'b0);
    apply(32'h0000_FFFF);
    idle_check();

    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      miscompares++;
      $display("FAIL watchdog expired got running expected finished");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
      $finish;
    end
  end

endmodule